// File: doc/BRIEF.md
# Keyed-Service Software Watchdog

This block is a system-protection timer. While enabled it counts clock cycles, optionally divided by an extra prescale stage. If firmware does not restart the count before the selected timeout, the block raises a one-cycle reset request and records that the watchdog caused the reset. Firmware talks to it through a simple synchronous write bus. One write select reaches a protection control register and the other reaches a service register.

The control register can be written only once after reset, so a runaway program cannot switch the watchdog off later. A restart needs two writes to the service register in order: a first key and then a second key. A single stray write cannot keep a crashed program alive. The halt-monitor and bus-monitor fields of the control register are held for neighbouring logic, and this block does not act on them.

Top module: `swdog_top`

## Requirements
- R1: After reset the control register reads 0xB0 (enabled, no extra prescale, timeout select 3, other fields 0). The reset request and the cause flag are both low.
- R2: The first control write (wr_sel=0) after reset is stored and restarts the count. Every later control write is ignored: the register does not change and the count is not restarted.
- R3: Control fields: bit 7 enable, bit 6 extra prescale, bits 5:4 timeout select, bit 3 halt-monitor enable, bit 2 bus-monitor external enable, bits 1:0 bus-monitor timing. Bits 3:0 are stored and read back, and have no effect on timing.
- R4: The timeout is 2^(BASE_LOG2 + STEP_LOG2*tsel) counted ticks. With the prescale bit set, each tick is 2^PRE_LOG2 clocks, and otherwise each tick is one clock.
- R5: A service write (wr_sel=1) of 0x55 followed by a service write of 0xAA restarts the count from zero at the 0xAA write.
- R6: A service write of 0x55 always arms the key detector. Any other service write disarms it, and no service write other than an armed 0xAA restarts the count. A lone 0xAA therefore has no effect.
- R7: When the count expires, rst_req is high for exactly one cycle. It rises P clocks after the last restart, where P is the period from R4, and the count then starts again.
- R8: wd_cause is set by an expiry and stays set until cause_clr is asserted. If an expiry and cause_clr fall in the same cycle, the flag is set.
- R9: With the enable bit clear the count is held at zero and rst_req never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | 0 selects control register, 1 selects service register |
| wr_data | input | 8 | Write data |
| cause_clr | input | 1 | Clears the watchdog cause flag (another reset cause or explicit clear) |
| ctrl_q | output | 8 | Current control register value |
| rst_req | output | 1 | One-cycle reset request on expiry |
| wd_cause | output | 1 | Watchdog-caused-reset flag |

## Verification
The assertions assume that every write lasts exactly one cycle with wr_sel and wr_data stable in that cycle. They also assume that cause_clr is an ordinary synchronous input, so the flag can only fall in the cycle after it. The stimulus drives all inputs from the falling clock edge, holds each write strobe for a single rising edge, and applies cause_clr only as a one-cycle pulse. Key sequences, stray service data and repeated control writes are all sent through the normal bus. This way the lock and the detector are exercised only by legal transactions.

// File: rtl/swdog_pkg.sv
package swdog_pkg;
  typedef struct packed {
    logic       en;
    logic       pre;
    logic [1:0] tsel;
    logic       halt_en;
    logic       bm_ext;
    logic [1:0] bm_tim;
  } ctrl_t;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam ctrl_t CTRL_RST = '{en: 1'b1, pre: 1'b0, tsel: 2'b11,
                                 halt_en: 1'b0, bm_ext: 1'b0, bm_tim: 2'b00};
endpackage

// File: rtl/swdog_keydet.sv
module swdog_keydet
  import swdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       svc_ok
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    svc_ok  = 1'b0;
    if (svc_wr) begin
      if (armed_q && svc_data == KEY_SECOND) begin
        svc_ok  = 1'b1;
        armed_d = 1'b0;
      end else begin
        armed_d = (svc_data == KEY_FIRST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/swdog_presc.sv
module swdog_presc #(
  parameter int PRE_LOG2 = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic pre_on,
  output logic tick
);
  generate
    if (PRE_LOG2 > 0) begin : g_div
      logic [PRE_LOG2-1:0] p_q, p_d;

      always_comb begin
        p_d = p_q;
        if (clr || !run) p_d = '0;
        else if (pre_on) p_d = p_q + 1'b1;
      end

      assign tick = run && (!pre_on || (&p_q));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
      end
    end else begin : g_nodiv
      logic unused_ok;
      assign unused_ok = clr ^ pre_on;
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/swdog_cnt.sv
module swdog_cnt #(
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] tsel,
  output logic       expire
);
  localparam int CW = BASE_LOG2 + STEP_LOG2 * 3;

  logic [CW-1:0] c_q, c_d, lim_m1;

  always_comb begin
    lim_m1 = (CW'(1) << (BASE_LOG2 + STEP_LOG2 * int'(tsel))) - CW'(1);
    expire = run && tick && (c_q == lim_m1);
    c_d    = c_q;
    if (clr || !run)  c_d = '0;
    else if (expire)  c_d = '0;
    else if (tick)    c_d = c_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= '0;
    else        c_q <= c_d;
  end
endmodule

// File: rtl/swdog_top.sv
module swdog_top
  import swdog_pkg::*;
#(
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2,
  parameter int PRE_LOG2  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       cause_clr,
  output logic [7:0] ctrl_q,
  output logic       rst_req,
  output logic       wd_cause
);
  ctrl_t ctrl_r, ctrl_d;
  logic  locked, locked_d;
  logic  req_d, cause_d;
  logic  svc_ok, tick, expire, restart, ctrl_take;

  assign ctrl_take = wr_en && !wr_sel && !locked;
  assign restart   = ctrl_take || svc_ok;

  swdog_keydet keydet_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_wr   (wr_en && wr_sel),
    .svc_data (wr_data),
    .svc_ok   (svc_ok)
  );

  swdog_presc #(.PRE_LOG2(PRE_LOG2)) presc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (restart),
    .run    (ctrl_r.en),
    .pre_on (ctrl_r.pre),
    .tick   (tick)
  );

  swdog_cnt #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (restart),
    .run    (ctrl_r.en),
    .tick   (tick),
    .tsel   (ctrl_r.tsel),
    .expire (expire)
  );

  always_comb begin
    ctrl_d   = ctrl_r;
    locked_d = locked;
    if (ctrl_take) begin
      ctrl_d   = ctrl_t'(wr_data);
      locked_d = 1'b1;
    end
    req_d   = expire;
    cause_d = wd_cause;
    if (expire)         cause_d = 1'b1;
    else if (cause_clr) cause_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r   <= CTRL_RST;
      locked   <= 1'b0;
      rst_req  <= 1'b0;
      wd_cause <= 1'b0;
    end else begin
      ctrl_r   <= ctrl_d;
      locked   <= locked_d;
      rst_req  <= req_d;
      wd_cause <= cause_d;
    end
  end

  assign ctrl_q = ctrl_r;
endmodule

// File: rtl/swdog_chk.sv
module swdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_q,
  input logic       rst_req,
  input logic       wd_cause,
  input logic       cause_clr,
  input logic       locked
);
  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R8
  cause_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> wd_cause);

  // R8
  cause_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_cause) |-> $past(cause_clr));

  // R2
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ctrl_q));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[7] |=> !rst_req);
endmodule

bind swdog_top swdog_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_q    (ctrl_q),
  .rst_req   (rst_req),
  .wd_cause  (wd_cause),
  .cause_clr (cause_clr),
  .locked    (locked)
);

// File: tb/swdog_top_tb_top.sv
`timescale 1ns/1ps
module swdog_top_tb_top;
  localparam int BASE = 4, STEP = 2, PRE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, cause_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_q;
  logic rst_req, wd_cause;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  swdog_top #(.BASE_LOG2(BASE), .STEP_LOG2(STEP), .PRE_LOG2(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cause_clr(cause_clr),
    .ctrl_q(ctrl_q), .rst_req(rst_req), .wd_cause(wd_cause)
  );

  // behavioural reference model
  logic [7:0] m_ctrl;
  bit m_lock, m_arm, m_req, m_flag;
  int m_n;

  function automatic int period(logic [7:0] c);
    int p = 1 << (BASE + STEP * int'(c[5:4]));
    if (c[6]) p = p * (1 << PRE);
    return p;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ctrl = 8'hB0; m_lock = 0; m_arm = 0; m_n = 0; m_req = 0; m_flag = 0;
    end else begin
      bit ex, rs, en_old;
      en_old = m_ctrl[7];
      ex = en_old && (m_n == period(m_ctrl) - 1);
      rs = 0;
      m_req = ex;
      if (ex) m_flag = 1; else if (cause_clr) m_flag = 0;
      if (wr_en && !wr_sel && !m_lock) begin
        m_ctrl = wr_data; m_lock = 1; rs = 1;
      end
      if (wr_en && wr_sel) begin
        if (m_arm && wr_data == 8'hAA) begin rs = 1; m_arm = 0; end
        else m_arm = (wr_data == 8'h55);
      end
      if (rs || !en_old || ex) m_n = 0;
      else m_n++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ctrl_q == m_ctrl, "R2 ctrl_q vs model", ctrl_q, m_ctrl);
      check(rst_req == m_req, "R7 rst_req vs model", rst_req, m_req);
      check(wd_cause == m_flag, "R8 wd_cause vs model", wd_cause, m_flag);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic bus_wr(bit sel, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  // waits for rst_req and returns cycles since t0 (-1 on timeout)
  task automatic wait_req(int t0, output int dt);
    dt = -1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (rst_req) begin dt = cyc - t0; break; end
    end
  endtask

  initial begin
    int t0, dt, seen;
    do_reset();
    t0 = cyc;
    // R1 reset state
    check(ctrl_q == 8'hB0, "R1 ctrl reset", ctrl_q, 8'hB0);
    check(!rst_req && !wd_cause, "R1 outputs low", {rst_req, wd_cause}, 0);
    // R4/R7 default period from reset release
    wait_req(t0, dt);
    check(dt == 1024, "R4 default period", dt, 1024);
    check(wd_cause, "R8 flag set on expiry", wd_cause, 1);
    @(negedge clk);
    check(!rst_req, "R7 one-cycle pulse", rst_req, 0);
    check(wd_cause, "R8 flag holds", wd_cause, 1);
    @(negedge clk); cause_clr = 1; @(negedge clk); cause_clr = 0;
    check(!wd_cause, "R8 flag cleared", wd_cause, 0);
    // R5 keyed service restarts
    repeat (300) @(negedge clk);
    bus_wr(1, 8'h55); bus_wr(1, 8'hAA); t0 = cyc;
    wait_req(t0, dt);
    check(dt == 1024, "R5 restart by key pair", dt, 1024);
    // R6 out-of-order and broken keys do not restart
    t0 = cyc;
    bus_wr(1, 8'hAA); bus_wr(1, 8'h55); bus_wr(1, 8'h33); bus_wr(1, 8'hAA);
    wait_req(t0, dt);
    check(dt == 1024, "R6 bad keys ignored", dt, 1024);
    // R6 re-arm: 55,55,AA restarts
    repeat (100) @(negedge clk);
    bus_wr(1, 8'h55); bus_wr(1, 8'h55); bus_wr(1, 8'hAA); t0 = cyc;
    wait_req(t0, dt);
    check(dt == 1024, "R6 55 re-arms", dt, 1024);
    // R2/R3/R4 one control write with prescale
    repeat (50) @(negedge clk);
    bus_wr(0, 8'hDE); t0 = cyc;
    check(ctrl_q == 8'hDE, "R3 fields stored", ctrl_q, 8'hDE);
    wait_req(t0, dt);
    check(dt == 256, "R4 prescaled period", dt, 256);
    t0 = cyc;
    bus_wr(0, 8'h00);
    check(ctrl_q == 8'hDE, "R2 second write ignored", ctrl_q, 8'hDE);
    wait_req(t0, dt);
    check(dt == 256, "R2 no restart on ignored write", dt, 256);
    // R8 clear and expiry in same cycle: set wins
    t0 = cyc;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (cyc - t0 == 255) begin cause_clr = 1; break; end
    end
    @(negedge clk); cause_clr = 0;
    check(rst_req && wd_cause, "R8 set wins over clear", {rst_req, wd_cause}, 3);
    // R4 shortest, and R3 low fields have no effect
    do_reset(); bus_wr(0, 8'h8F); t0 = cyc;
    wait_req(t0, dt);
    check(dt == 16, "R4 tsel0 period / R3 low bits inert", dt, 16);
    do_reset(); bus_wr(0, 8'h90); t0 = cyc;
    wait_req(t0, dt);
    check(dt == 64, "R4 tsel1 period", dt, 64);
    // R9 disabled
    do_reset(); bus_wr(0, 8'h30);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (rst_req) seen++;
    end
    check(seen == 0, "R9 disabled never expires", seen, 0);
    check(!wd_cause, "R9 flag stays clear", wd_cause, 0);
    finish_run();
  end

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #900000;
    total++; bad++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    finish_run();
  end
endmodule